// File: doc/BRIEF.md
# Inclusive Last-Level Cache Snoop Directory

This block tracks which lines are resident in a shared last-level cache that includes the contents of every private core cache above it. For each resident line it keeps a tag and a vector with one presence flag per core. A flag is raised whenever that core's private caches may hold the line. The block takes one lookup at a time. A lookup is either a plain read or a read for ownership, and it names the requesting core. For each lookup the block returns three things: whether the line was found, whether memory has to supply it, and which cores must be snooped.

Inclusion makes a miss cheap. A line missing from the directory cannot be in any core, so a miss needs no snoops and goes straight to memory. On a miss the block allocates a way in the indexed 4-way set. If the chosen line still has presence flags raised, the block first sends a back-invalidate for that line to the marked cores and waits for it to be accepted. Only then does it overwrite the way and answer.

All three interfaces are valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A response or back-invalidate holds all of its fields stable from the cycle its valid rises until the cycle its ready is seen high. The block cannot start another lookup until the response has been accepted.

Top module: `snoop_filter_dir`

## Requirements
- R1: A lookup whose line is not resident answers with hit=0, mem=1 and an empty snoop mask.
- R2: A read that hits a line whose only raised flag belongs to a different core answers with hit=1, mem=0, and a snoop mask holding just that core.
- R3: A read that hits a line with two or more flags raised answers with an empty snoop mask. A read that hits a line marked only for the requester also answers with an empty snoop mask.
- R4: A read for ownership that hits snoops every marked core except the requester. Afterwards only the requester's flag stays raised, so a later read from another core snoops exactly that requester.
- R5: A fill raises the requester's flag, and a read hit adds it. As a result, a repeat read by a core that was already snooped for shares the line and causes no snoop.
- R6: Victim selection in a set picks the lowest-numbered invalid way first. When all ways are valid, it uses a tree pseudo-LRU with bits s[2:0], all zero at reset. If s0=0 the victim is way {0,s1}, otherwise way {1,s2}. Touching way w (on a hit or a fill) sets s0 to the inverse of w[1]. It also sets s1 (when w[1]=0) or s2 (when w[1]=1) to the inverse of w[0].
- R7: Evicting a valid line with a nonzero flag vector raises a back-invalidate whose address is the victim's full line address ({tag, set}) and whose mask is its flag vector. The response appears only after that back-invalidate has been accepted. A victim with no flags raised is dropped silently.
- R8: `req_ready` is low from the accepting edge until the response is accepted. Response and back-invalidate fields stay stable while their valid is high and their ready is low.
- R9: After reset, `req_ready`=1, `rsp_valid`=0 and `binv_valid`=0, and every way is invalid.
- R10: Once a line has been evicted, a later lookup of it misses.
- R11: The line address splits as set = addr[SET_W-1:0] and tag = addr[ADDR_W-1:SET_W]. The snoop mask, the back-invalidate mask and the flag vectors use bit i for core i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle and able to take a lookup |
| req_addr | input | ADDR_W | Line address of the lookup |
| req_core | input | $clog2(NCORE) | Requesting core index |
| req_excl | input | 1 | 1 = read for ownership, 0 = plain read |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_hit | output | 1 | Line was resident |
| rsp_mem | output | 1 | Memory must supply the line |
| rsp_snoop | output | NCORE | Cores to snoop, bit per core |
| binv_valid | output | 1 | Back-invalidate valid |
| binv_ready | input | 1 | Back-invalidate accepted |
| binv_addr | output | ADDR_W | Line address being evicted |
| binv_mask | output | NCORE | Cores that must drop the line |

## Verification
A corrupted flag vector shows up at the ports as a wrong snoop mask on the next hit to that line. It also shows up as a wrong back-invalidate mask when the line is evicted. A wrong tag or valid bit turns into a hit/miss mismatch on the next access to that line. A pseudo-LRU fault shows up as a back-invalidate for the wrong address, or as a later unexpected miss, within a few lookups to a full set. Sequencing faults are visible within the same lookup: a response that arrives before its back-invalidate, fields that change while stalled, or `req_ready` rising while busy.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_BINV = 2'd2,
    ST_RSP  = 2'd3
  } sf_state_e;
endpackage

// File: rtl/sf_way_match.sv
module sf_way_match
  import sf_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_vals,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       free_any,
  output logic [WAY_W-1:0]           free_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_vals[w] && (set_tags[w] == look_tag);
  end

  always_comb begin
    hit      = |match;
    free_any = ~&set_vals;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])     hit_way  = WAY_W'(w);
      if (!set_vals[w]) free_way = WAY_W'(w);
    end
  end

  // R10
  always_comb begin
    a_r10_onehot_match_chk: assert ($onehot0(match));
  end
endmodule

// File: rtl/sf_plru.sv
module sf_plru
  import sf_pkg::*;
(
  input  logic [2:0]       cur,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim,
  output logic [2:0]       nxt
);
  always_comb begin
    victim = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
    nxt    = cur;
    nxt[0] = ~touch_way[1];
    if (touch_way[1]) nxt[2] = ~touch_way[0];
    else              nxt[1] = ~touch_way[0];
  end
endmodule

// File: rtl/sf_snoop_policy.sv
module sf_snoop_policy #(
  parameter int NCORE  = 4,
  parameter int CORE_W = 2
) (
  input  logic [NCORE-1:0]  pres,
  input  logic [CORE_W-1:0] core,
  input  logic              excl,
  input  logic              hit,
  output logic [NCORE-1:0]  own,
  output logic [NCORE-1:0]  snoop,
  output logic [NCORE-1:0]  pres_next
);
  logic [NCORE-1:0] others;
  logic             single;

  always_comb begin
    own    = '0;
    own[core] = 1'b1;
    others = pres & ~own;
    single = ($countones(pres) == 1);
    if (!hit)      snoop = '0;
    else if (excl) snoop = others;
    else           snoop = single ? others : '0;
    pres_next = excl ? own : (pres | own);
  end

  // R2
  always_comb begin
    a_r2_read_snoop_single_chk: assert (excl || $onehot0(snoop));
  end
endmodule

// File: rtl/snoop_filter_dir.sv
module snoop_filter_dir
  import sf_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 12,
  parameter int SET_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [$clog2(NCORE)-1:0]    req_core,
  input  logic                        req_excl,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_hit,
  output logic                        rsp_mem,
  output logic [NCORE-1:0]            rsp_snoop,
  output logic                        binv_valid,
  input  logic                        binv_ready,
  output logic [ADDR_W-1:0]           binv_addr,
  output logic [NCORE-1:0]            binv_mask
);
  localparam int CORE_W = $clog2(NCORE);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int SETS   = 1 << SET_W;

  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0]            val_q  [SETS];
  logic [WAYS-1:0][NCORE-1:0] pres_q [SETS];
  logic [2:0]                 plru_q [SETS];

  sf_state_e          st;
  logic [ADDR_W-1:0]  rq_addr;
  logic [CORE_W-1:0]  rq_core;
  logic               rq_excl;
  logic [WAY_W-1:0]   vic_q;

  logic [SET_W-1:0]   rq_set;
  logic [TAG_W-1:0]   rq_tag;
  logic               hit, free_any;
  logic [WAY_W-1:0]   hit_way, free_way, plru_vic, pick_way, touch_way;
  logic [2:0]         plru_nxt;
  logic [NCORE-1:0]   own, snoop, pres_next, hit_pres, pick_pres;

  assign rq_set = rq_addr[SET_W-1:0];
  assign rq_tag = rq_addr[ADDR_W-1:SET_W];

  sf_way_match #(.TAG_W(TAG_W)) u_match (
    .set_tags (tag_q[rq_set]),
    .set_vals (val_q[rq_set]),
    .look_tag (rq_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .free_any (free_any),
    .free_way (free_way)
  );

  assign pick_way  = free_any ? free_way : plru_vic;
  assign touch_way = (st == ST_BINV) ? vic_q : (hit ? hit_way : pick_way);
  assign hit_pres  = pres_q[rq_set][hit_way];
  assign pick_pres = pres_q[rq_set][pick_way];

  sf_plru u_plru (
    .cur       (plru_q[rq_set]),
    .touch_way (touch_way),
    .victim    (plru_vic),
    .nxt       (plru_nxt)
  );

  sf_snoop_policy #(.NCORE(NCORE), .CORE_W(CORE_W)) u_policy (
    .pres      (hit_pres),
    .core      (rq_core),
    .excl      (rq_excl),
    .hit       (hit),
    .own       (own),
    .snoop     (snoop),
    .pres_next (pres_next)
  );

  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RSP);
  assign binv_valid = (st == ST_BINV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rq_addr   <= '0;
      rq_core   <= '0;
      rq_excl   <= 1'b0;
      vic_q     <= '0;
      rsp_hit   <= 1'b0;
      rsp_mem   <= 1'b0;
      rsp_snoop <= '0;
      binv_addr <= '0;
      binv_mask <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        val_q[s]  <= '0;
        pres_q[s] <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          rq_addr <= req_addr;
          rq_core <= req_core;
          rq_excl <= req_excl;
          st      <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit) begin
            pres_q[rq_set][hit_way] <= pres_next;
            plru_q[rq_set]          <= plru_nxt;
            rsp_hit   <= 1'b1;
            rsp_mem   <= 1'b0;
            rsp_snoop <= snoop;
            st        <= ST_RSP;
          end else begin
            rsp_hit   <= 1'b0;
            rsp_mem   <= 1'b1;
            rsp_snoop <= '0;
            if (val_q[rq_set][pick_way] && (pick_pres != '0)) begin
              vic_q     <= pick_way;
              binv_addr <= {tag_q[rq_set][pick_way], rq_set};
              binv_mask <= pick_pres;
              st        <= ST_BINV;
            end else begin
              tag_q[rq_set][pick_way]  <= rq_tag;
              val_q[rq_set][pick_way]  <= 1'b1;
              pres_q[rq_set][pick_way] <= own;
              plru_q[rq_set]           <= plru_nxt;
              st                       <= ST_RSP;
            end
          end
        end
        ST_BINV: if (binv_ready) begin
          tag_q[rq_set][vic_q]  <= rq_tag;
          val_q[rq_set][vic_q]  <= 1'b1;
          pres_q[rq_set][vic_q] <= own;
          plru_q[rq_set]        <= plru_nxt;
          st                    <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  miss_no_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_mem && rsp_snoop == '0));

  // R4
  no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_snoop[rq_core]);

  // R7
  binv_before_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && binv_ready) |=> (rsp_valid && !binv_valid));

  // R7
  binv_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> (binv_mask != '0));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_hit) && $stable(rsp_mem) && $stable(rsp_snoop)));

  // R8
  binv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && !binv_ready) |=>
      (binv_valid && $stable(binv_addr) && $stable(binv_mask)));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_valid));
endmodule

// File: tb/snoop_filter_dir_bench.sv
module snoop_filter_dir_bench;
  localparam int NCORE = 4;
  localparam int ADDR_W = 12;
  localparam int SET_W = 2;
  localparam int TAG_W = ADDR_W - SET_W;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_excl = 0, rsp_ready = 0, binv_ready = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_core = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_mem, binv_valid;
  logic [NCORE-1:0] rsp_snoop, binv_mask;
  logic [ADDR_W-1:0] binv_addr;

  always #5 clk = ~clk;

  snoop_filter_dir u_snoop_filter_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_core(req_core), .req_excl(req_excl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_mem(rsp_mem), .rsp_snoop(rsp_snoop),
    .binv_valid(binv_valid), .binv_ready(binv_ready),
    .binv_addr(binv_addr), .binv_mask(binv_mask)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [TAG_W-1:0] mtag [4][4];
  bit               mval [4][4];
  logic [3:0]       mpres[4][4];
  logic [2:0]       mplru[4];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] plru_victim(input logic [2:0] s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] s, input logic [1:0] w);
    logic [2:0] n;
    n = s;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0]; else n[1] = ~w[0];
    return n;
  endfunction

  function automatic logic [3:0] exp_snoop(input logic [3:0] pres, input int core, input bit excl);
    logic [3:0] others;
    others = pres & ~(4'b1 << core);
    if (excl) return others;
    return ($countones(pres) == 1) ? others : 4'b0;
  endfunction

  task automatic do_req(input int core, input int tag, input int set, input bit excl);
    int hw, vw;
    bit ehit, ebinv, binv_done, got;
    logic [3:0] esnoop, emask;
    logic [ADDR_W-1:0] eaddr;
    string slabel;
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (mval[set][w] && mtag[set][w] == TAG_W'(tag)) hw = w;
    ehit = (hw >= 0);
    ebinv = 0; emask = '0; eaddr = '0; esnoop = '0;
    if (ehit) begin
      esnoop = exp_snoop(mpres[set][hw], core, excl);
      mpres[set][hw] = excl ? (4'b1 << core) : (mpres[set][hw] | (4'b1 << core));
      mplru[set] = plru_touch(mplru[set], 2'(hw));
    end else begin
      vw = -1;
      for (int w = 3; w >= 0; w--) if (!mval[set][w]) vw = w;
      if (vw < 0) vw = int'(plru_victim(mplru[set]));
      if (mval[set][vw] && mpres[set][vw] != 0) begin
        ebinv = 1; emask = mpres[set][vw];
        eaddr = {mtag[set][vw], 2'(set)};
      end
      mtag[set][vw] = TAG_W'(tag); mval[set][vw] = 1;
      mpres[set][vw] = 4'b1 << core;
      mplru[set] = plru_touch(mplru[set], 2'(vw));
    end
    slabel = !ehit ? "R1" : (excl ? "R4" : "R2 R3 R5");

    @(negedge clk);
    req_valid = 1; req_core = 2'(core); req_excl = excl;
    req_addr = {TAG_W'(tag), 2'(set)};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    binv_done = 0; got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      chk(!req_ready, "R8 busy", req_ready, 0);
      if (binv_valid) begin
        chk(ebinv, "R7 binv expected", 1, ebinv);
        chk(binv_addr == eaddr, "R6 R7 binv addr", binv_addr, eaddr);
        chk(binv_mask == emask, "R7 binv mask", binv_mask, emask);
        binv_ready = ($urandom % 3) != 0;
        if (binv_ready) binv_done = 1;
      end else binv_ready = 0;
      if (rsp_valid) begin
        chk(!ebinv || binv_done, "R7 rsp after binv", binv_done, 1);
        chk(rsp_hit == ehit, "R6 R10 hit", rsp_hit, ehit);
        chk(rsp_mem == !ehit, "R1 mem", rsp_mem, !ehit);
        chk(rsp_snoop == esnoop, slabel, rsp_snoop, esnoop);
        rsp_ready = ($urandom % 3) != 0;
        if (rsp_ready) got = 1;
      end else rsp_ready = 0;
      @(negedge clk);
    end
    chk(got, "R8 response handshake", got, 1);
    rsp_ready = 0; binv_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < 4; s++) begin
      mplru[s] = '0;
      for (int w = 0; w < 4; w++) begin mval[s][w] = 0; mpres[s][w] = '0; mtag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1, "R9 req_ready", req_ready, 1);
    chk(rsp_valid == 0, "R9 rsp_valid", rsp_valid, 0);
    chk(binv_valid == 0, "R9 binv_valid", binv_valid, 0);

    // Directed: sharing and ownership on set 0, R11 address split {tag,set}
    do_req(0, 1, 0, 0);  // R1 miss fill, core 0
    do_req(1, 1, 0, 0);  // R2 snoop core 0
    do_req(2, 1, 0, 0);  // R3 two flags raised -> no snoop
    do_req(3, 1, 0, 1);  // R4 snoop 0,1,2
    do_req(0, 1, 0, 0);  // R4 only core 3 remains
    do_req(1, 1, 0, 0);  // R3 shared read
    do_req(0, 1, 0, 0);  // R5 repeat read, no snoop
    // R6 fill remaining ways, then force PLRU evictions with back-invalidates
    do_req(2, 2, 0, 0);
    do_req(2, 3, 0, 1);
    do_req(3, 4, 0, 0);
    do_req(1, 5, 0, 0);  // R7 eviction
    do_req(0, 6, 0, 1);  // R7 eviction
    do_req(0, 1, 0, 0);  // R10 evicted line re-misses if chosen
    do_req(2, 2, 0, 0);

    for (int n = 0; n < 500; n++)
      do_req(int'($urandom % 4), int'($urandom % 7), int'($urandom % 4), ($urandom % 3) == 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule